// File: doc/BRIEF.md
# DMA Channel Progress Event Generator

This block watches the progress of one DMA channel and raises two one-cycle pulses: a half-way pulse and a completion pulse. A 2-bit granularity selector decides what a completion means. It can be each data block, each linked-list item (counted after that item's descriptor update), or the whole channel, which ends with the final item. The channel's transfer engine supplies the byte count programmed for the current unit and a remaining count that decrements as the data moves. It also supplies strobes for channel start, data-block end, descriptor update finished, and "the descriptor just loaded is the final one". The final descriptor is the one that writes a zero link address and clears every update flag.

The half-way pulse fires once per unit. It fires in the first cycle in which the remaining count is at or below half of the programmed count, rounded down. If the first item was programmed with a zero byte count, the block emits no events for that item. The one exception is channel granularity, where the completion pulse is raised as soon as the next item has finished loading. When the channel runs an endless circular list at channel granularity, the block stays silent. Both outputs are registered, so each pulse appears one cycle after the input condition that causes it.

Top module: `tce_event_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, both pulses are low. Nothing fires before a channel start.
- R2: With mode 00, a block-end strobe produces a completion pulse on the next cycle. The only exception is when that block is a zero-length first item.
- R3: Mode 01 behaves exactly like mode 00.
- R4: A unit begins at channel start, or at a unit boundary (block end in modes 0x, update done in modes 1x). Within a unit, the half pulse fires once, one cycle after the first cycle in which the programmed count is nonzero, the unit is armed, and remaining <= floor(count/2). It never fires in the cycle of a unit boundary itself.
- R5: With mode 10, the completion pulse follows the update-done strobe by one cycle. Block-end strobes produce no completion in this mode.
- R6: With mode 11, the completion pulse follows update-done only once the final-item strobe has been seen since channel start. The half pulse is enabled only during that final item.
- R7: With mode 11 and the continuous flag set, neither pulse fires.
- R8: If the channel starts with a zero programmed count in modes 00, 01 or 10, the first unit gives neither a half pulse nor a completion pulse. Later units behave normally.
- R9: If the channel starts with a zero programmed count in mode 11, the completion pulse follows the first update-done, whether or not the final-item strobe has been seen.
- R10: The half pulse is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Event granularity: 00/01 block, 10 item, 11 channel |
| blk_len_i | input | CW | Byte count programmed for the current unit |
| remain_i | input | CW | Bytes still to move in the current unit |
| chan_start_i | input | 1 | Channel activation strobe; the programmed count belongs to the first item |
| blk_end_i | input | 1 | Data block finished strobe |
| upd_done_i | input | 1 | Item finished, including any descriptor update |
| last_item_i | input | 1 | Final descriptor loaded (zero link, no update flags) |
| cont_i | input | 1 | Channel runs a circular, endless list |
| half_o | output | 1 | Half-way pulse |
| done_o | output | 1 | Completion pulse |

## Verification
The bench builds the block with an 8-bit count (CW = 8). Odd counts then exercise the rounded-down half-way point. A block of 255, the largest count, probes the top of the range without an excessive run length. Each granularity mode is stepped through multi-unit channels, zero-length first items, and a circular list. A behavioural model predicts both pulses, and the two are compared on every clock.

// File: rtl/tce_pkg.sv
package tce_pkg;
  typedef enum logic [1:0] {
    TCE_BLOCK     = 2'b00,
    TCE_BLOCK_ALT = 2'b01,
    TCE_ITEM      = 2'b10,
    TCE_CHAN      = 2'b11
  } tce_mode_e;
endpackage

// File: rtl/tce_half_detect.sv
module tce_half_detect #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          rearm_i,
  input  logic          en_i,
  input  logic [CW-1:0] len_i,
  input  logic [CW-1:0] remain_i,
  output logic          fire_o
);
  logic          armed_q;
  logic [CW-1:0] mid;

  assign mid    = len_i >> 1;
  assign fire_o = armed_q & ~rearm_i & en_i & (len_i != '0) & (remain_i <= mid);

  always_ff @(posedge clk_i) begin
    if (rst_i)        armed_q <= 1'b0;
    else if (rearm_i) armed_q <= 1'b1;
    else if (fire_o)  armed_q <= 1'b0;
  end

  AST_FIRE_ONLY_ARMED: assert property (@(posedge clk_i) disable iff (rst_i)
    fire_o |=> !fire_o || $past(rearm_i)); // R10
endmodule

// File: rtl/tce_item_state.sv
module tce_item_state #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          chan_start_i,
  input  logic          unit_end_i,
  input  logic          last_item_i,
  input  logic [CW-1:0] len_i,
  output logic          first_null_o,
  output logic          last_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      first_null_o <= 1'b0;
      last_o       <= 1'b0;
    end else begin
      if (chan_start_i)    first_null_o <= (len_i == '0);
      else if (unit_end_i) first_null_o <= 1'b0;
      if (last_item_i)       last_o <= 1'b1;
      else if (chan_start_i) last_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tce_event_gen.sv
module tce_event_gen
  import tce_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] blk_len_i,
  input  logic [CW-1:0] remain_i,
  input  logic          chan_start_i,
  input  logic          blk_end_i,
  input  logic          upd_done_i,
  input  logic          last_item_i,
  input  logic          cont_i,
  output logic          half_o,
  output logic          done_o
);
  tce_mode_e md;
  logic item_lvl, unit_end, rearm, half_en, half_fire, done_d;
  logic first_null, last_seen;

  assign md       = tce_mode_e'(mode_i);
  assign item_lvl = (md == TCE_ITEM) || (md == TCE_CHAN);
  assign unit_end = item_lvl ? upd_done_i : blk_end_i;
  assign rearm    = chan_start_i | unit_end;
  assign half_en  = (md == TCE_CHAN) ? (last_seen & ~cont_i) : 1'b1;

  tce_item_state #(.CW(CW)) u_state (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .chan_start_i (chan_start_i),
    .unit_end_i   (unit_end),
    .last_item_i  (last_item_i),
    .len_i        (blk_len_i),
    .first_null_o (first_null),
    .last_o       (last_seen)
  );

  tce_half_detect #(.CW(CW)) u_half (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rearm_i  (rearm),
    .en_i     (half_en),
    .len_i    (blk_len_i),
    .remain_i (remain_i),
    .fire_o   (half_fire)
  );

  always_comb begin
    unique case (md)
      TCE_BLOCK, TCE_BLOCK_ALT: done_d = blk_end_i & ~first_null;
      TCE_ITEM:                 done_d = upd_done_i & ~first_null;
      TCE_CHAN:                 done_d = upd_done_i & ~cont_i & (first_null | last_seen);
      default:                  done_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      half_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      half_o <= half_fire;
      done_o <= done_d;
    end
  end

  AST_HALF_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    half_o |=> !half_o); // R10
  AST_HALF_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    half_o |-> $past(blk_len_i) != '0); // R4
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> $past(blk_end_i) || $past(upd_done_i)); // R2
  AST_ITEM_DONE_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o && $past(mode_i[1]) |-> $past(upd_done_i)); // R5
  AST_CONT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o || half_o) |-> !($past(mode_i) == 2'b11 && $past(cont_i))); // R7
endmodule

// File: tb/tce_event_gen_tb.sv
module tce_event_gen_tb_top;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic [CW-1:0] len = '0, remain = '0;
  logic          cs = 1'b0, be = 1'b0, ud = 1'b0, li = 1'b0, cont = 1'b0;
  logic          half, done;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_armed, m_fnull, m_last, m_half, m_done;

  always #4 clk = ~clk;

  tce_event_gen #(.CW(CW)) dut_i (
    .clk_i(clk), .rst_i(rst), .mode_i(mode), .blk_len_i(len), .remain_i(remain),
    .chan_start_i(cs), .blk_end_i(be), .upd_done_i(ud), .last_item_i(li),
    .cont_i(cont), .half_o(half), .done_o(done)
  );

  task automatic model_step();
    bit bound, start, hen, nh, nd;
    int l, r;
    l = len; r = remain;
    if (rst) begin
      m_armed = 0; m_fnull = 0; m_last = 0; m_half = 0; m_done = 0;
      return;
    end
    bound = (mode >= 2) ? ud : be;
    start = cs || bound;
    if (mode == 3) hen = m_last && !cont; else hen = 1;
    nh = !start && m_armed && hen && (l > 0) && (2 * r <= l);
    case (mode)
      0, 1: nd = be && !m_fnull;
      2:    nd = ud && !m_fnull;
      default: nd = ud && !cont && (m_fnull || m_last);
    endcase
    if (start) m_armed = 1; else if (nh) m_armed = 0;
    if (cs) m_fnull = (l == 0); else if (bound) m_fnull = 0;
    if (li) m_last = 1; else if (cs) m_last = 0;
    m_half = nh; m_done = nd;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    checks += 2;
    if (half !== m_half) begin
      errors++;
      $display("FAIL %s half: actual %0b expected %0b at %0t", cur_req, half, m_half, $time);
    end
    if (done !== m_done) begin
      errors++;
      $display("FAIL %s done: actual %0b expected %0b at %0t", cur_req, done, m_done, $time);
    end
    cs = 0; be = 0; ud = 0; li = 0;
  endtask

  task automatic start_chan(input int l, input bit last);
    len = l[CW-1:0]; remain = l[CW-1:0]; cs = 1; li = last;
    tick();
  endtask

  task automatic run_data(input int l);
    len = l[CW-1:0];
    for (int r = l; r >= 0; r--) begin
      remain = r[CW-1:0];
      tick();
    end
    be = 1; tick();
    tick();
  endtask

  task automatic item_end(input int next_len, input bit next_last);
    ud = 1; tick();
    len = next_len[CW-1:0]; remain = next_len[CW-1:0]; li = next_last;
    tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) tick();
    rst = 0;
    len = 8'd6; remain = 8'd2;
    repeat (4) tick();          // armed never set: R1 quiet before start

    cur_req = "R2"; mode = 2'b00;
    start_chan(10, 0); run_data(10);
    cur_req = "R4"; run_data(7);       // odd count, half at remain 3
    run_data(1);
    run_data(255);
    cur_req = "R3"; mode = 2'b01;
    start_chan(9, 0); run_data(9); run_data(4);

    cur_req = "R5"; mode = 2'b10;
    start_chan(8, 0); run_data(8); item_end(5, 0);
    run_data(5); item_end(0, 0);

    cur_req = "R6"; mode = 2'b11;
    start_chan(6, 0); run_data(6); item_end(9, 1);
    run_data(9); item_end(0, 0);
    tick();

    cur_req = "R7"; cont = 1;
    start_chan(6, 1); run_data(6); item_end(6, 0);
    run_data(6); item_end(0, 0);
    cont = 0;

    cur_req = "R8"; mode = 2'b00;
    start_chan(0, 0); be = 1; tick(); tick();
    run_data(4);
    mode = 2'b10;
    start_chan(0, 0); run_data(0); item_end(6, 0);
    run_data(6); item_end(0, 0);

    cur_req = "R9"; mode = 2'b11;
    start_chan(0, 0); item_end(4, 1);
    run_data(4); item_end(0, 0);

    cur_req = "R10"; mode = 2'b00;
    start_chan(2, 0); run_data(2); run_data(3);
    repeat (3) tick();
    finish_run();
  end
endmodule